// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the processor-facing register bank of a four-channel DMA controller. Software reaches it through a narrow byte-wide I/O port with a 4-bit port offset, separate write and read strobes and a data byte. Each channel owns a 16-bit start address and a 16-bit transfer count. Because the port is only eight bits wide, each 16-bit register is reached through a single offset: a shared byte-pointer flip-flop selects the low byte on the first access and the high byte on the next.

The bank also keeps a 6-bit mode per channel, a four-bit channel mask, a command byte and a sticky terminal-count status nibble. Masks and modes are not given one offset per channel. Instead, the target channel is carried in the low two bits of the written data byte. The programmed values, the per-channel modes and a per-channel enable are driven out to a transfer engine, which reports end of transfer back through a per-channel terminal-count pulse. Address counting, arbitration and the transfer cycles themselves belong to that engine and are not in this block.

Top module: `dmaRegBank`

## Requirements
- R1: After reset, all four mask bits are set, the command byte is 0x00, the status flags are clear, every address and count is 0x0000, every mode is zero, every channel enable is low and the byte pointer selects the low byte.
- R2: Channel n's address is at port offset 2n and its count at offset 2n+1 (n = 0..3). A write stores the data byte into the low byte when the pointer is clear and into the high byte when it is set. A read returns the selected byte of the stored value. The stored values appear on `chanAddr` and `chanCount`, with channel n in bits [16n+15:16n].
- R3: The byte pointer toggles after every read or write of offsets 0 to 7. Any write to offset 0x0C clears it. Accesses to offsets 0x08 to 0x0F do not toggle it.
- R4: A write to offset 0x0A selects the channel with data bits 1:0. Data bit 2 set masks that channel and data bit 2 clear unmasks it. The other mask bits keep their values.
- R5: A write to offset 0x0E clears all four mask bits. A write to offset 0x0F loads mask bit n from data bit n.
- R6: A write to offset 0x0B selects the channel with data bits 1:0 and stores data bits 7:2 as that channel's 6-bit mode on `chanMode` bits [6n+5:6n]. Within the mode, bits 1:0 are direction, bit 2 is auto-initialise, bit 3 is address decrement and bits 5:4 are the mode type. For example, 0x44 yields mode 0x11 and 0xC0 yields mode 0x30.
- R7: A write to offset 0x08 loads the command byte. A read of offset 0x08 returns the status byte, with bits 3:0 holding the terminal-count flags and bits 7:4 reading as zero.
- R8: A `tcPulse[n]` sets terminal-count flag n, which then holds. Reading the status byte clears the flags, except that a pulse in the same cycle as the read leaves its flag set.
- R9: A write to offset 0x0D (master clear) sets all mask bits, clears the byte pointer, the command byte and the status flags. Addresses, counts and modes are kept.
- R10: A count register holds the transfer length minus one and is read back unchanged, so 0xFFFF stands for 65536 transfers and a finished transfer reads 0xFFFF.
- R11: `chanEnable[n]` is high exactly when mask bit n is clear and command bit 2 (controller disable) is clear.
- R12: A write to offset 0x09 changes nothing. A read of any offset from 0x09 to 0x0F returns 0x00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portOfs | input | 4 | Port offset of the access |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access (ignored while wrEn is high) |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte, valid in the cycle rdEn is high |
| tcPulse | input | 4 | Terminal-count pulse per channel from the transfer engine |
| chanAddr | output | 64 | Programmed address, 16 bits per channel |
| chanCount | output | 64 | Programmed count (length minus one), 16 bits per channel |
| chanMode | output | 24 | Mode, 6 bits per channel |
| chanMask | output | 4 | Channel mask bits |
| cmdByte | output | 8 | Command byte |
| chanEnable | output | 4 | Per-channel enable to the transfer engine |

## Verification
The main stimulus is a seeded random mix of byte writes and reads to the eight register offsets, interleaved with pointer clears. This interleaving separates a pointer that toggles on every register access from one that toggles only on writes, or one that also toggles on control ports. Random single-mask, mask-all, mask-clear and mode writes with random channel fields show whether the channel select comes from the data byte and whether neighbouring channels are disturbed. Directed cases cover the other corners:
- the named mode values;
- a count of 0xFFFF;
- a master clear after programming, which must keep the addresses;
- a terminal-count pulse coinciding with a status read;
- the controller-disable command bit;
- writes to the request offset and reads of write-only offsets, each followed by a register read that shows whether the pointer moved.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int CH_CNT    = 4;
  localparam int DATA_W    = 8;
  localparam int REG_W     = 16;
  localparam int MODE_W    = 6;
  localparam int PORT_W    = 4;
  localparam int REG_PORTS = 2 * CH_CNT;
  localparam int IDX_W     = $clog2(REG_PORTS);
  localparam int CH_W      = $clog2(CH_CNT);
  localparam int DIS_BIT   = 2;

  localparam logic [PORT_W-1:0] OFS_CMD     = 4'h8;
  localparam logic [PORT_W-1:0] OFS_MASKONE = 4'hA;
  localparam logic [PORT_W-1:0] OFS_MODE    = 4'hB;
  localparam logic [PORT_W-1:0] OFS_PTRCLR  = 4'hC;
  localparam logic [PORT_W-1:0] OFS_MCLR    = 4'hD;
  localparam logic [PORT_W-1:0] OFS_MASKCLR = 4'hE;
  localparam logic [PORT_W-1:0] OFS_MASKSET = 4'hF;

  typedef struct packed {
    logic [REG_PORTS-1:0] regWr;
    logic                 regRd;
    logic [IDX_W-1:0]     regIdx;
    logic                 hiSel;
    logic                 cmdWr;
    logic                 statusRd;
    logic                 maskOne;
    logic                 maskSet;
    logic                 maskClr;
    logic                 modeWr;
    logic                 masterClr;
  } regStb_t;
endpackage

// File: rtl/dmaRegCtrl.sv
module dmaRegCtrl
  import dmaRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] portOfs,
  input  logic              wrEn,
  input  logic              rdEn,
  output regStb_t           stb
);
  logic bytePtr;
  logic rdAct;
  logic regPort;
  logic regAccess;
  logic ptrClear;

  assign rdAct     = rdEn & ~wrEn;
  assign regPort   = int'(portOfs) < REG_PORTS;
  assign regAccess = regPort & (wrEn | rdAct);
  assign ptrClear  = wrEn & ((portOfs == OFS_PTRCLR) | (portOfs == OFS_MCLR));

  always_ff @(posedge clk) begin
    if (!rstN)           bytePtr <= 1'b0;
    else if (ptrClear)   bytePtr <= 1'b0;
    else if (regAccess)  bytePtr <= ~bytePtr;
  end

  always_comb begin
    stb           = '0;
    stb.regIdx    = portOfs[IDX_W-1:0];
    stb.hiSel     = bytePtr;
    stb.regRd     = rdAct & regPort;
    for (int i = 0; i < REG_PORTS; i++)
      stb.regWr[i] = wrEn & (int'(portOfs) == i);
    stb.cmdWr     = wrEn  & (portOfs == OFS_CMD);
    stb.statusRd  = rdAct & (portOfs == OFS_CMD);
    stb.maskOne   = wrEn  & (portOfs == OFS_MASKONE);
    stb.modeWr    = wrEn  & (portOfs == OFS_MODE);
    stb.masterClr = wrEn  & (portOfs == OFS_MCLR);
    stb.maskClr   = wrEn  & (portOfs == OFS_MASKCLR);
    stb.maskSet   = wrEn  & (portOfs == OFS_MASKSET);
  end

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (regAccess && !ptrClear) |=> (bytePtr != $past(bytePtr)));  // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!regAccess && !ptrClear) |=> $stable(bytePtr));  // R12
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ptrClear |=> !bytePtr);  // R3

  always_comb begin
    if (rstN) AST_ONE_REG_STROBE: assert ($onehot0(stb.regWr));  // R2
  end
endmodule

// File: rtl/dmaRegData.sv
module dmaRegData
  import dmaRegPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  regStb_t                  stb,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [CH_CNT-1:0]        tcPulse,
  output logic [DATA_W-1:0]        rdData,
  output logic [CH_CNT*REG_W-1:0]  chanAddr,
  output logic [CH_CNT*REG_W-1:0]  chanCount,
  output logic [CH_CNT*MODE_W-1:0] chanMode,
  output logic [CH_CNT-1:0]        chanMask,
  output logic [DATA_W-1:0]        cmdByte,
  output logic [CH_CNT-1:0]        chanEnable
);
  localparam int HALF_W = REG_W / 2;

  logic [REG_W-1:0]  regFile [REG_PORTS];
  logic [CH_CNT-1:0] tcFlags;
  logic [CH_W-1:0]   chSel;

  assign chSel = wrData[CH_W-1:0];

  for (genvar r = 0; r < REG_PORTS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) regFile[r] <= '0;
      else if (stb.regWr[r]) begin
        if (stb.hiSel) regFile[r][REG_W-1:HALF_W] <= wrData;
        else           regFile[r][HALF_W-1:0]     <= wrData;
      end
    end
  end

  for (genvar c = 0; c < CH_CNT; c++) begin : g_ch
    logic [MODE_W-1:0] modeQ;

    always_ff @(posedge clk) begin
      if (!rstN)                                chanMask[c] <= 1'b1;
      else if (stb.masterClr)                   chanMask[c] <= 1'b1;
      else if (stb.maskClr)                     chanMask[c] <= 1'b0;
      else if (stb.maskSet)                     chanMask[c] <= wrData[c];
      else if (stb.maskOne && chSel == CH_W'(c)) chanMask[c] <= wrData[2];
    end

    always_ff @(posedge clk) begin
      if (!rstN) modeQ <= '0;
      else if (stb.modeWr && chSel == CH_W'(c))
        modeQ <= wrData[DATA_W-1:DATA_W-MODE_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN)              tcFlags[c] <= 1'b0;
      else if (stb.masterClr) tcFlags[c] <= 1'b0;
      else if (tcPulse[c])    tcFlags[c] <= 1'b1;
      else if (stb.statusRd)  tcFlags[c] <= 1'b0;
    end

    assign chanAddr[c*REG_W +: REG_W]    = regFile[2*c];
    assign chanCount[c*REG_W +: REG_W]   = regFile[2*c+1];
    assign chanMode[c*MODE_W +: MODE_W]  = modeQ;
    assign chanEnable[c] = ~chanMask[c] & ~cmdByte[DIS_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cmdByte <= '0;
    else if (stb.masterClr) cmdByte <= '0;
    else if (stb.cmdWr)     cmdByte <= wrData;
  end

  always_comb begin
    rdData = '0;
    if (stb.regRd)
      rdData = stb.hiSel ? regFile[stb.regIdx][REG_W-1:HALF_W]
                         : regFile[stb.regIdx][HALF_W-1:0];
    else if (stb.statusRd)
      rdData = {{(DATA_W-CH_CNT){1'b0}}, tcFlags};
  end

  AST_MCLR_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    stb.masterClr |=> (&chanMask && cmdByte == '0));  // R9
  AST_STATUS_RDCLR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.statusRd && tcPulse == '0) |=> (tcFlags == '0));  // R8
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.statusRd && !stb.masterClr) |=> ((tcFlags & $past(tcFlags)) == $past(tcFlags)));  // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWr == '0) |=> ($stable(chanAddr) && $stable(chanCount)));  // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.modeWr |=> $stable(chanMode));  // R6

  always_comb begin
    if (rstN) AST_EN_GATED: assert ((chanEnable & chanMask) == '0);  // R11
  end
endmodule

// File: rtl/dmaRegBank.sv
module dmaRegBank
  import dmaRegPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PORT_W-1:0]        portOfs,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  input  logic [CH_CNT-1:0]        tcPulse,
  output logic [CH_CNT*REG_W-1:0]  chanAddr,
  output logic [CH_CNT*REG_W-1:0]  chanCount,
  output logic [CH_CNT*MODE_W-1:0] chanMode,
  output logic [CH_CNT-1:0]        chanMask,
  output logic [DATA_W-1:0]        cmdByte,
  output logic [CH_CNT-1:0]        chanEnable
);
  regStb_t stb;

  dmaRegCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .portOfs (portOfs),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .stb     (stb)
  );

  dmaRegData u_data (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .tcPulse    (tcPulse),
    .rdData     (rdData),
    .chanAddr   (chanAddr),
    .chanCount  (chanCount),
    .chanMode   (chanMode),
    .chanMask   (chanMask),
    .cmdByte    (cmdByte),
    .chanEnable (chanEnable)
  );
endmodule

// File: tb/dmaRegBank_bench.sv
module dmaRegBank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  portOfs = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [3:0]  tcPulse = '0;
  logic [63:0] chanAddr;
  logic [63:0] chanCount;
  logic [23:0] chanMode;
  logic [3:0]  chanMask;
  logic [7:0]  cmdByte;
  logic [3:0]  chanEnable;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench model of the register bank
  logic [15:0] mReg [8];
  logic [5:0]  mMode [4];
  logic [3:0]  mMask;
  logic [7:0]  mCmd;
  logic [3:0]  mStat;
  logic        mPtr;

  always #2.5 clk = ~clk;

  dmaRegBank u_dmaRegBank (
    .clk(clk), .rstN(rstN), .portOfs(portOfs), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .tcPulse(tcPulse), .chanAddr(chanAddr),
    .chanCount(chanCount), .chanMode(chanMode), .chanMask(chanMask),
    .cmdByte(cmdByte), .chanEnable(chanEnable)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] expAddr();
    logic [63:0] v;
    for (int c = 0; c < 4; c++) v[c*16 +: 16] = mReg[2*c];
    return v;
  endfunction

  function automatic logic [63:0] expCount();
    logic [63:0] v;
    for (int c = 0; c < 4; c++) v[c*16 +: 16] = mReg[2*c+1];
    return v;
  endfunction

  function automatic logic [23:0] expMode();
    logic [23:0] v;
    for (int c = 0; c < 4; c++) v[c*6 +: 6] = mMode[c];
    return v;
  endfunction

  function automatic logic [3:0] expEnable();
    return ~mMask & {4{~mCmd[2]}};
  endfunction

  function automatic logic [7:0] expRead(logic [3:0] ofs);
    if (ofs < 4'h8) return mPtr ? mReg[ofs[2:0]][15:8] : mReg[ofs[2:0]][7:0];
    if (ofs == 4'h8) return {4'h0, mStat};
    return 8'h00;
  endfunction

  function automatic void modelWrite(logic [3:0] ofs, logic [7:0] d);
    if (ofs < 4'h8) begin
      if (mPtr) mReg[ofs[2:0]][15:8] = d;
      else      mReg[ofs[2:0]][7:0]  = d;
      mPtr = ~mPtr;
    end else begin
      case (ofs)
        4'h8: mCmd = d;
        4'hA: mMask[d[1:0]] = d[2];
        4'hB: mMode[d[1:0]] = d[7:2];
        4'hC: mPtr = 1'b0;
        4'hD: begin mMask = 4'hF; mPtr = 1'b0; mCmd = 8'h00; mStat = 4'h0; end
        4'hE: mMask = 4'h0;
        4'hF: mMask = d[3:0];
        default: ;
      endcase
    end
  endfunction

  function automatic void modelRead(logic [3:0] ofs);
    if (ofs < 4'h8) mPtr = ~mPtr;
    else if (ofs == 4'h8) mStat = 4'h0;
  endfunction

  task automatic busWr(logic [3:0] ofs, logic [7:0] d);
    @(negedge clk);
    portOfs = ofs; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(ofs, d);
  endtask

  task automatic busRd(string tag, logic [3:0] ofs);
    logic [7:0] got;
    @(negedge clk);
    portOfs = ofs; rdEn = 1'b1;
    #1 got = rdData;
    @(negedge clk);
    rdEn = 1'b0;
    chk(tag, 64'(got), 64'(expRead(ofs)));
    modelRead(ofs);
  endtask

  task automatic checkOuts(string tag);
    chk({tag, " addr"},   chanAddr,   expAddr());
    chk({tag, " count"},  chanCount,  expCount());
    chk({tag, " mode"},   64'(chanMode),   64'(expMode()));
    chk({tag, " mask"},   64'(chanMask),   64'(mMask));
    chk({tag, " cmd"},    64'(cmdByte),    64'(mCmd));
    chk({tag, " enable"}, 64'(chanEnable), 64'(expEnable()));
  endtask

  task automatic pulseTc(logic [3:0] v);
    @(negedge clk);
    tcPulse = v;
    @(negedge clk);
    tcPulse = '0;
    mStat = mStat | v;
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 8; i++) mReg[i] = '0;
    for (int c = 0; c < 4; c++) mMode[c] = '0;
    mMask = 4'hF; mCmd = '0; mStat = '0; mPtr = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkOuts("R1 reset");
    busRd("R1 status after reset", 4'h8);
    busRd("R1 low byte first", 4'h0);
    busWr(4'hC, 8'h00);

    // R2 / R3 / R10: 16-bit programming via byte pairs
    busWr(4'h2, 8'h34); busWr(4'h2, 8'h12);
    busWr(4'h7, 8'hFF); busWr(4'h7, 8'hFF);
    checkOuts("R2 byte pairs");
    chk("R10 count of 65536", chanCount[63:48], 64'hFFFF);
    busRd("R10 count low", 4'h7); busRd("R10 count high", 4'h7);
    busRd("R2 addr low", 4'h2);
    busWr(4'hC, 8'h5A);
    busRd("R3 low after pointer clear", 4'h2);

    // R6 named mode values
    busWr(4'hB, 8'h44); busWr(4'hB, 8'h49); busWr(4'hB, 8'h56); busWr(4'hB, 8'hC3);
    chk("R6 mode 0x44", 64'(chanMode[5:0]), 64'h11);
    chk("R6 mode 0x48", 64'(chanMode[11:6]), 64'h12);
    chk("R6 mode 0x54", 64'(chanMode[17:12]), 64'h15);
    chk("R6 mode 0xC0", 64'(chanMode[23:18]), 64'h30);

    // R4 / R5 / R11 masks and controller disable
    busWr(4'hE, 8'h00); checkOuts("R5 clear all");
    busWr(4'hA, 8'h06); checkOuts("R4 mask ch2");
    busWr(4'hA, 8'h02); checkOuts("R4 unmask ch2");
    busWr(4'hF, 8'hF9); checkOuts("R5 load mask");
    busWr(4'h8, 8'h04); checkOuts("R11 disable bit");
    busWr(4'h8, 8'h00); checkOuts("R11 enable again");

    // R7 / R8 status and terminal count
    pulseTc(4'b0101);
    busRd("R7 status read", 4'h8);
    busRd("R8 status cleared", 4'h8);
    pulseTc(4'b0010);
    @(negedge clk);
    portOfs = 4'h8; rdEn = 1'b1; tcPulse = 4'b1000;
    #1 chk("R8 read with pulse", 64'(rdData), 64'h02);
    @(negedge clk);
    rdEn = 1'b0; tcPulse = '0; mStat = 4'b1000;
    busRd("R8 coinciding pulse kept", 4'h8);

    // R12 ignored ports, pointer must not move
    busWr(4'h4, 8'hAB);
    busWr(4'h9, 8'hFF);
    busRd("R12 read 0x0A", 4'hA);
    busRd("R12 read 0x0F", 4'hF);
    busWr(4'h4, 8'hCD);
    checkOuts("R12 no side effect");

    // R9 master clear keeps addresses, counts and modes
    busWr(4'h8, 8'h10); busWr(4'hE, 8'h00); busWr(4'h0, 8'h77);
    pulseTc(4'b0001);
    busWr(4'hD, 8'h00);
    checkOuts("R9 master clear");
    busRd("R9 status zero", 4'h8);
    busRd("R9 pointer low", 4'h0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 9);
      d = 8'($urandom);
      case (op)
        0, 1: busWr(4'($urandom % 8), d);
        2:    busRd("R2 random read", 4'($urandom % 8));
        3:    busWr(4'hA, d);
        4:    busWr(4'hB, d);
        5:    busWr(4'hC, d);
        6:    busWr(($urandom % 2) ? 4'hE : 4'hF, d);
        7:    busWr(4'h8, d);
        default: if ($urandom % 2) pulseTc(4'(d)); else busRd("R7 random status", 4'h8);
      endcase
      checkOuts("R3 random");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule